// File: doc/BRIEF.md
# GPIO Interrupt Sense and Status Unit

This block detects interrupt conditions on a bank of general-purpose input pins, grouped as several ports of eight pins each. Every pin has a three-bit trigger type: rising edge, falling edge, either edge, high level or low level. Every pin also has a status bit that records a detected condition and an enable bit that lets that condition reach the port's interrupt line. A small register bus sets the types and enables, reads the status and clears edge events.

Each port drives its own interrupt line. That line is asserted when any pin of the port has both its status bit and its enable bit set. A bank line is the OR of all port lines. The pin inputs must already be synchronised to the clock. Edges are found by comparing each sample with the one taken one clock earlier.

Bus map, per port p (0 to 3): byte address = alias*0x800 + reg + 4*p. The value of reg is 0x40 for status, 0x50 for enable, 0x60 for type and 0x70 for clear. Setting alias to 1 selects the masked-write form. Reads return the plain register value, with unused high bits at zero. Writes take effect at the clock edge where the write strobe is sampled high.

Top module: `gpio_irq_bank`

## Requirements
- R1: A pin whose type has polarity bit n = 1, edge bit n+8 = 1 and both-edge bit n+16 = 0 (0x000101 << n) sets its status bit on a 0-to-1 input change only. The status bit is visible at the clock edge that samples the new level.
- R2: A type of 0x000100 << n (edge bit set, polarity clear, both-edge clear) sets the status bit on a 1-to-0 change only.
- R3: A type of 0x010100 << n (edge bit and both-edge bit set) sets the status bit on any input change.
- R4: With the edge bit clear, the status bit equals the input, or the inverted input when the polarity bit is 0, one clock after sampling. Writes to the clear register have no lasting effect on such a pin. After reset all types are 0 (low level), so pins held low read status 1.
- R5: Writing the clear register at 0x70 clears each edge-type status bit whose data bit is 1. Bits written as 0 leave status unchanged.
- R6: An edge detected in the same cycle as a clear write to that pin leaves the status bit set.
- R7: A write to the masked enable alias 0x850 updates enable bit n to data bit n only where data bit n+8 is 1. Other enable bits are unchanged. A plain write to 0x50 loads all eight bits.
- R8: A port's interrupt output is 1 exactly when some pin has both its status bit and its enable bit at 1. The bank interrupt is the OR of the port interrupts.
- R9: A type write clears the written pin's status bit and restarts its edge history. An input change sampled in the same cycle as the type write, or in the cycle after it, is not reported.
- R10: A write to the masked type alias 0x860 uses data bits 31:24 as per-pin selects. For a selected pin n, it loads type bits n, n+8 and n+16 from the same data positions. Unselected pins keep their type.
- R11: A write to the masked status alias 0x840 sets or clears the status bit of edge-type pin n to data bit n where data bit n+8 is 1.
- R12: During reset, all port interrupts, enables and types are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pins_in | input | PORTS*PINS (32) | Synchronised pin levels, port p pin n at bit p*8+n |
| port_irq | output | PORTS (4) | Per-port interrupt lines |
| bank_irq | output | 1 | OR of all port interrupt lines |

## Verification
A corrupted previous-sample bit or edge-history flag causes a false edge, or a missed edge, one clock after the faulty sample. The error shows on port_irq when that pin is enabled, and otherwise in a status read. Wrong type or enable storage shows in a read of the same register at once. It also turns interrupts on or off for pins whose inputs should not matter. Faulty clear priority shows only when a clear coincides with an edge, so the bench creates that collision on purpose and checks the line one cycle later.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int unsigned ADDR_W = 12;
    localparam int unsigned DATA_W = 32;

    // register field codes in address bits 7:4
    localparam logic [3:0] FLD_STATUS = 4'h4;
    localparam logic [3:0] FLD_ENABLE = 4'h5;
    localparam logic [3:0] FLD_TYPE   = 4'h6;
    localparam logic [3:0] FLD_CLEAR  = 4'h7;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_STATUS,
        RK_ENABLE,
        RK_TYPE,
        RK_CLEAR
    } reg_kind_e;

    typedef struct packed {
        logic      masked;
        reg_kind_e kind;
    } bus_op_t;

endpackage

// File: rtl/gpio_irq_decode.sv
module gpio_irq_decode
    import gpio_irq_pkg::*;
#(
    parameter int unsigned PORTS = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output bus_op_t           op,
    output logic [PORTS-1:0]  port_sel
);

    logic [3:0] fld;
    logic [1:0] pfield;
    logic       shape_ok;

    assign fld      = addr[7:4];
    assign pfield   = addr[3:2];
    assign shape_ok = (addr[1:0] == 2'b00) && (addr[10:8] == 3'b000);

    always_comb begin
        op.masked = addr[11];
        op.kind   = RK_NONE;
        if (shape_ok) begin
            unique case (fld)
                FLD_STATUS: op.kind = RK_STATUS;
                FLD_ENABLE: op.kind = RK_ENABLE;
                FLD_TYPE:   op.kind = RK_TYPE;
                FLD_CLEAR:  op.kind = addr[11] ? RK_NONE : RK_CLEAR;
                default:    op.kind = RK_NONE;
            endcase
        end
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_sel
        assign port_sel[p] = (op.kind != RK_NONE) && (pfield == 2'(p));
    end

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int unsigned PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  bus_op_t           op,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PINS-1:0]   pins,
    output logic [PINS-1:0]   sta,
    output logic [PINS-1:0]   en,
    output logic [3*PINS-1:0] typ,
    output logic              irq
);

    localparam int unsigned TYP_W   = 3*PINS;
    localparam int unsigned SEL_LSB = DATA_W - PINS;

    typedef struct packed {
        logic [PINS-1:0]  sta;
        logic [PINS-1:0]  en;
        logic [PINS-1:0]  prev;
        logic [PINS-1:0]  hist_ok;
        logic [TYP_W-1:0] typ;
        logic             live;
    } pstate_t;

    pstate_t cur_q, nxt_d;

    logic [PINS-1:0] pol, edge_mode, both;
    logic [PINS-1:0] rise, fall, sel_edge, hit, match;
    logic [PINS-1:0] typ_wr_pin, clr_bits, sw_sel, kept;
    logic            is_typ, is_en, is_clr, is_sta_m;

    assign pol       = cur_q.typ[0 +: PINS];
    assign edge_mode = cur_q.typ[PINS +: PINS];
    assign both      = cur_q.typ[2*PINS +: PINS];

    assign is_typ   = we && (op.kind == RK_TYPE);
    assign is_en    = we && (op.kind == RK_ENABLE);
    assign is_clr   = we && (op.kind == RK_CLEAR);
    assign is_sta_m = we && (op.kind == RK_STATUS) && op.masked;

    always_comb begin
        rise     = pins & ~cur_q.prev;
        fall     = ~pins & cur_q.prev;
        sel_edge = (both & (rise | fall)) | (~both & pol & rise) | (~both & ~pol & fall);
        match    = (pol & pins) | (~pol & ~pins);

        typ_wr_pin = '0;
        if (is_typ) typ_wr_pin = op.masked ? wdata[SEL_LSB +: PINS] : '1;

        hit      = sel_edge & edge_mode & cur_q.hist_ok & ~typ_wr_pin;
        clr_bits = is_clr ? wdata[PINS-1:0] : '0;
        sw_sel   = is_sta_m ? wdata[PINS +: PINS] : '0;
        kept     = ((cur_q.sta & ~sw_sel) | (wdata[PINS-1:0] & sw_sel)) & ~clr_bits;
    end

    always_comb begin
        nxt_d         = cur_q;
        nxt_d.live    = 1'b1;
        nxt_d.prev    = pins;
        nxt_d.hist_ok = ~typ_wr_pin;

        if (is_en) begin
            if (op.masked)
                nxt_d.en = (cur_q.en & ~wdata[PINS +: PINS]) | (wdata[PINS-1:0] & wdata[PINS +: PINS]);
            else
                nxt_d.en = wdata[PINS-1:0];
        end

        for (int n = 0; n < PINS; n++) begin
            if (typ_wr_pin[n]) begin
                nxt_d.typ[n]        = wdata[n];
                nxt_d.typ[PINS+n]   = wdata[PINS+n];
                nxt_d.typ[2*PINS+n] = wdata[2*PINS+n];
            end
        end

        nxt_d.sta = ((edge_mode & (kept | hit)) | (~edge_mode & match)) & ~typ_wr_pin;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign sta = cur_q.sta;
    assign en  = cur_q.en;
    assign typ = cur_q.typ;
    assign irq = |(cur_q.sta & cur_q.en);

    logic [PINS-1:0] clr_eff;
    assign clr_eff = clr_bits & edge_mode & ~hit;

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_eff) |=> ((cur_q.sta & $past(clr_eff)) == '0)); // R5
    AST_EDGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> ((cur_q.sta & $past(hit)) == $past(hit))); // R6
    AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.live |-> (((cur_q.sta ^ $past(match)) & $past(~edge_mode & ~typ_wr_pin)) == '0)); // R4
    AST_EN_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (is_en && op.masked) |=> (((cur_q.en ^ $past(cur_q.en)) & ~$past(wdata[PINS +: PINS])) == '0)); // R7
    AST_TYPE_WR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (|typ_wr_pin) |=> ((cur_q.sta & $past(typ_wr_pin)) == '0)); // R9

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int unsigned PORTS = 4,
    parameter int unsigned PINS  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic [PORTS*PINS-1:0] pins_in,
    output logic [PORTS-1:0]      port_irq,
    output logic                  bank_irq
);

    localparam int unsigned TYP_W = 3*PINS;

    bus_op_t          op;
    logic [PORTS-1:0] port_sel;
    logic [PINS-1:0]  sta_a [PORTS];
    logic [PINS-1:0]  en_a  [PORTS];
    logic [TYP_W-1:0] typ_a [PORTS];

    gpio_irq_decode #(.PORTS(PORTS)) u_dec (
        .addr     (bus_addr),
        .op       (op),
        .port_sel (port_sel)
    );

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        gpio_irq_port #(.PINS(PINS)) u_port (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bus_we && port_sel[p]),
            .op    (op),
            .wdata (bus_wdata),
            .pins  (pins_in[p*PINS +: PINS]),
            .sta   (sta_a[p]),
            .en    (en_a[p]),
            .typ   (typ_a[p]),
            .irq   (port_irq[p])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < PORTS; p++) begin
            if (port_sel[p]) begin
                case (op.kind)
                    RK_STATUS: bus_rdata[PINS-1:0]  = sta_a[p];
                    RK_ENABLE: bus_rdata[PINS-1:0]  = en_a[p];
                    RK_TYPE:   bus_rdata[TYP_W-1:0] = typ_a[p];
                    default:   bus_rdata = '0;
                endcase
            end
        end
    end

    assign bank_irq = |port_irq;

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (port_irq == '0 && !bank_irq)); // R12

endmodule

// File: tb/tb_gpio_irq_bank.sv
`timescale 1ns/1ps
module tb_gpio_irq_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pins = '0;
    logic [3:0]  port_irq;
    logic        bank_irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_irq_bank dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pins_in   (pins),
        .port_irq  (port_irq),
        .bank_irq  (bank_irq)
    );

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];
    item_t it;
    logic [31:0] got;

    // monitor: compares queued expectations mid-cycle
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            it  = sb.pop_front();
            got = (it.kind == 0) ? bus_rdata : {27'b0, bank_irq, port_irq};
            total++;
            if (got !== it.exp) begin
                bad++;
                $display("FAIL %s actual=%h expected=%h", it.tag, got, it.exp);
            end
        end
    end

    function automatic logic [11:0] ra(input bit m, input logic [3:0] f, input int p);
        return {m, 3'b000, f, 2'(p), 2'b00};
    endfunction

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic wr_pins(input logic [11:0] a, input logic [31:0] d, input logic [31:0] pv);
        @(posedge clk); #1;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d; pins = pv;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic set_pins(input logic [31:0] pv);
        @(posedge clk); #1;
        pins = pv;
        @(posedge clk); #1;
    endtask

    task automatic chk_irq(input logic [4:0] e, input string tag);
        item_t x;
        x.kind = 1; x.exp = {27'b0, e}; x.tag = tag;
        sb.push_back(x);
        @(negedge clk); #1;
    endtask

    task automatic chk_rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        item_t x;
        bus_addr = a;
        x.kind = 0; x.exp = e; x.tag = tag;
        sb.push_back(x);
        @(negedge clk); #1;
    endtask

    localparam logic [3:0] F_STA = 4'h4, F_EN = 4'h5, F_TYP = 4'h6, F_CLR = 4'h7;

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk_irq(5'b0_0000, "R12 irq in reset");
        chk_rd(ra(0, F_EN, 0), 32'h0, "R12 enable in reset");
        chk_rd(ra(0, F_TYP, 0), 32'h0, "R12 type in reset");
        @(posedge clk); #1; rst_n = 1'b1;
        tick();
        chk_rd(ra(0, F_STA, 0), 32'h0000_00ff, "R4 level-low default status");

        // R1 rising
        wr(ra(0, F_TYP, 0), 32'h0000_0101);
        wr(ra(0, F_EN, 0), 32'h0000_0001);
        tick();
        chk_irq(5'b0_0000, "R1 no edge yet");
        set_pins(32'h1);
        chk_irq(5'b1_0001, "R1 rise sets, R8 bank");
        wr(ra(0, F_CLR, 0), 32'h1);
        chk_irq(5'b0_0000, "R5 clear edge status");
        set_pins(32'h0);
        chk_irq(5'b0_0000, "R1 fall ignored");

        // R5 zero bits
        set_pins(32'h1);
        wr(ra(0, F_CLR, 0), 32'hffff_fffe);
        chk_irq(5'b1_0001, "R5 zero bit no effect");
        wr(ra(0, F_CLR, 0), 32'h1);
        chk_irq(5'b0_0000, "R5 clear");

        // R2 falling
        wr(ra(0, F_TYP, 0), 32'h0000_0100);
        tick(); tick();
        set_pins(32'h0);
        chk_irq(5'b1_0001, "R2 fall sets");
        wr(ra(0, F_CLR, 0), 32'h1);
        set_pins(32'h1);
        chk_irq(5'b0_0000, "R2 rise ignored");

        // R3 both
        wr(ra(0, F_TYP, 0), 32'h0001_0100);
        tick(); tick();
        set_pins(32'h0);
        chk_irq(5'b1_0001, "R3 fall sets");
        wr(ra(0, F_CLR, 0), 32'h1);
        chk_irq(5'b0_0000, "R3 cleared");
        set_pins(32'h1);
        chk_irq(5'b1_0001, "R3 rise sets");
        wr(ra(0, F_CLR, 0), 32'h1);

        // R6 edge coincident with clear
        wr_pins(ra(0, F_CLR, 0), 32'h1, 32'h0);
        chk_irq(5'b1_0001, "R6 edge beats clear");
        wr(ra(0, F_CLR, 0), 32'h1);
        chk_irq(5'b0_0000, "R6 later clear");

        // R4 level high
        wr(ra(0, F_TYP, 0), 32'h0000_0001);
        tick();
        chk_irq(5'b0_0000, "R4 level high idle");
        set_pins(32'h1);
        chk_irq(5'b1_0001, "R4 level high asserts");
        wr(ra(0, F_CLR, 0), 32'h1);
        chk_irq(5'b1_0001, "R4 clear no lasting effect");
        set_pins(32'h0);
        chk_irq(5'b0_0000, "R4 level drops");
        chk_rd(ra(0, F_STA, 0), 32'h0000_00fe, "R4 status follows levels");

        // R7 masked enable
        wr(ra(1, F_EN, 0), 32'h0000_0202);
        chk_rd(ra(0, F_EN, 0), 32'h0000_0003, "R7 masked set pin1");
        chk_irq(5'b1_0001, "R8 pin1 pending");
        wr(ra(1, F_EN, 0), 32'h0000_0100);
        chk_rd(ra(0, F_EN, 0), 32'h0000_0002, "R7 masked clear pin0");

        // R8 bank over ports
        wr(ra(0, F_EN, 2), 32'h0000_0080);
        chk_irq(5'b1_0101, "R8 two ports");
        wr(ra(0, F_EN, 0), 32'h0);
        wr(ra(0, F_EN, 2), 32'h0);
        chk_irq(5'b0_0000, "R8 all off");

        // R10 masked type
        wr(ra(1, F_TYP, 0), 32'h0400_0404);
        chk_rd(ra(0, F_TYP, 0), 32'h0000_0405, "R10 masked type merge");

        // R9 type write with coincident edge
        wr(ra(0, F_EN, 0), 32'h0000_0004);
        chk_irq(5'b0_0000, "R9 pin2 idle");
        wr_pins(ra(1, F_TYP, 0), 32'h0400_0404, 32'h4);
        chk_irq(5'b0_0000, "R9 coincident edge dropped");
        tick();
        chk_irq(5'b0_0000, "R9 still quiet");
        set_pins(32'h0);
        set_pins(32'h4);
        chk_irq(5'b1_0001, "R9 later edge reported");

        // R11 masked status
        wr(ra(0, F_CLR, 0), 32'h4);
        chk_irq(5'b0_0000, "R11 cleared first");
        wr(ra(1, F_STA, 0), 32'h0000_0404);
        chk_irq(5'b1_0001, "R11 masked set");
        wr(ra(1, F_STA, 0), 32'h0000_0400);
        chk_irq(5'b0_0000, "R11 masked clear");

        tick();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule